// File: doc/BRIEF.md
# Processor Mode and Privilege Controller

This block keeps the execution context of a small processor core: whether the core runs ordinary thread code or an exception handler, whether the running code is privileged, and which of two banked stack pointers (main or process) is in use. An exception sequencer sends a strobe when it enters an exception and another when it leaves one. With the exit strobe it supplies a two-bit return code that names the context to resume. Software reads and writes a two-bit context control register through a simple port. The active stack pointer is read and written through a single port that always targets the visible bank.

Unprivileged thread code can never grant itself privilege. Privilege comes back only through exception entry. When the handler returns to thread code, the thread privilege held before entry comes back with it, because the handler leaves the control register untouched unless it writes it. Writes made inside a handler change the stored thread settings, and these take effect once the core returns to thread mode.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset the block is in thread mode (handler_mode_o=0) with privileged_o=1, psp_active_o=0, ctrl_rdata_o=2'b00, the main stack bank holding MSP_RST and the process bank holding PSP_RST.
- R2: An exception entry strobe moves the block to handler mode on the next cycle. In handler mode privileged_o=1 and psp_active_o=0, whatever the control bits hold.
- R3: A control write from privileged thread code updates both control bits on the next cycle. Bit 0 set to 1 means unprivileged thread execution, and bit 1 set to 1 selects the process stack in thread mode.
- R4: A control write issued while the block is in thread mode with bit 0 = 1 (unprivileged) is ignored entirely. ctrl_rdata_o and privileged_o keep their values.
- R5: An exit strobe in handler mode with return code bit 0 = 1 returns to thread mode. The privilege is then taken from control bit 0, so the privilege held before entry comes back if the handler did not write it.
- R6: A control write in handler mode is accepted. privileged_o stays 1 until return, and after the return the written bit 0 decides thread privilege.
- R7: An exit strobe with return code bit 0 = 0 keeps the block in handler mode (nested return). An exit strobe in thread mode has no effect.
- R8: On a return to thread mode, return code bit 1 is loaded into control bit 1 and selects the thread stack (1 = process, 0 = main).
- R9: sp_rdata_o shows the bank selected by psp_active_o. A stack-pointer write goes to that bank with its two low bits forced to zero.
- R10: When entry and exit strobes arrive in the same cycle, entry wins and the block is in handler mode on the next cycle, with no change to the control bits from the return code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_enter_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception exit strobe |
| exc_ret_code_i | input | 2 | Return code: bit 0 = return to thread, bit 1 = use process stack |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 2 | Control write data: bit 0 unprivileged, bit 1 process stack |
| ctrl_rdata_o | output | 2 | Stored control bits |
| handler_mode_o | output | 1 | 1 in handler mode, 0 in thread mode |
| privileged_o | output | 1 | Current code has privileged access |
| psp_active_o | output | 1 | Process stack pointer is the visible bank |
| sp_we_i | input | 1 | Stack pointer write enable (active bank) |
| sp_wdata_i | input | SP_W | Stack pointer write data |
| sp_rdata_o | output | SP_W | Active stack pointer value |

## Verification
The hardest case to reach is the one where the privilege restored on return differs from what a naive design would pick. To get there, the code must first drop privilege, try and fail to win it back, take an exception, and then either return untouched or rewrite bit 0 inside the handler. The stimulus table walks this chain in order and includes tail-chained cycles, where entry and exit strobes coincide, and nested returns that stay in handler mode. A directed sequence then moves between the two stack banks across entry and return, writing unaligned values, so it shows that each write lands only in the bank visible at that moment.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } exec_mode_e;

    // Bit positions inside the control word and the return code.
    localparam int CTRL_NPRIV_BIT = 0;
    localparam int CTRL_SPSEL_BIT = 1;
    localparam int RET_THREAD_BIT = 0;
    localparam int RET_SPSEL_BIT  = 1;

    typedef struct packed {
        exec_mode_e mode;
        logic       npriv;  // thread code runs unprivileged
        logic       spsel;  // thread code uses process stack
    } ctx_state_t;

    localparam ctx_state_t CTX_RESET = '{mode: MODE_THREAD, npriv: 1'b0, spsel: 1'b0};

endpackage

// File: rtl/pmc_ctx_fsm.sv
module pmc_ctx_fsm
    import pmc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enter_i,
    input  logic       ret_i,
    input  logic [1:0] ret_code_i,
    input  logic       ctrl_we_i,
    input  logic [1:0] ctrl_wdata_i,
    output ctx_state_t state_o
);

    ctx_state_t st_d, st_q;
    logic       in_handler;
    logic       write_ok;
    logic       back_to_thread;

    always_comb begin
        st_d           = st_q;
        in_handler     = (st_q.mode == MODE_HANDLER);
        // Unprivileged thread code may not touch the control word at all.
        write_ok       = ctrl_we_i && (in_handler || !st_q.npriv);
        back_to_thread = ret_i && in_handler && ret_code_i[RET_THREAD_BIT];

        if (write_ok) begin
            st_d.npriv = ctrl_wdata_i[CTRL_NPRIV_BIT];
            st_d.spsel = ctrl_wdata_i[CTRL_SPSEL_BIT];
        end

        if (enter_i) begin
            // Entry wins over a coincident exit: tail-chained handler.
            st_d.mode = MODE_HANDLER;
        end else if (back_to_thread) begin
            st_d.mode  = MODE_THREAD;
            st_d.spsel = ret_code_i[RET_SPSEL_BIT];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= CTX_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/pmc_sp_banks.sv
module pmc_sp_banks #(
    parameter int              SP_W       = 32,
    parameter int              ALIGN_BITS = 2,
    parameter logic [SP_W-1:0] MSP_RST    = '0,
    parameter logic [SP_W-1:0] PSP_RST    = '0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sel_i,
    input  logic            we_i,
    input  logic [SP_W-1:0] wdata_i,
    output logic [SP_W-1:0] rdata_o
);

    localparam int              NUM_BANKS = 2;
    localparam logic [SP_W-1:0] KEEP_MASK =
        {{(SP_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
    localparam logic [SP_W-1:0] RST_TAB [NUM_BANKS] = '{MSP_RST & KEEP_MASK,
                                                         PSP_RST & KEEP_MASK};

    logic [SP_W-1:0] bank_d [NUM_BANKS];
    logic [SP_W-1:0] bank_q [NUM_BANKS];

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_d[b] = bank_q[b];
            if (we_i && (int'(sel_i) == b)) begin
                bank_d[b] = wdata_i & KEEP_MASK;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!rst_ni) begin
                bank_q[b] <= RST_TAB[b];
            end else begin
                bank_q[b] <= bank_d[b];
            end
        end
    end

    assign rdata_o = bank_q[sel_i];

endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int              SP_W       = 32,
    parameter int              ALIGN_BITS = 2,
    parameter logic [SP_W-1:0] MSP_RST    = 32'h2000_0000,
    parameter logic [SP_W-1:0] PSP_RST    = 32'h1000_0000
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            exc_enter_i,
    input  logic            exc_return_i,
    input  logic [1:0]      exc_ret_code_i,
    input  logic            ctrl_we_i,
    input  logic [1:0]      ctrl_wdata_i,
    output logic [1:0]      ctrl_rdata_o,
    output logic            handler_mode_o,
    output logic            privileged_o,
    output logic            psp_active_o,
    input  logic            sp_we_i,
    input  logic [SP_W-1:0] sp_wdata_i,
    output logic [SP_W-1:0] sp_rdata_o
);

    ctx_state_t ctx;
    logic       in_handler;

    pmc_ctx_fsm u_ctx (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .enter_i      (exc_enter_i),
        .ret_i        (exc_return_i),
        .ret_code_i   (exc_ret_code_i),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .state_o      (ctx)
    );

    assign in_handler     = (ctx.mode == MODE_HANDLER);
    assign handler_mode_o = in_handler;
    assign privileged_o   = in_handler || !ctx.npriv;
    assign psp_active_o   = !in_handler && ctx.spsel;
    assign ctrl_rdata_o   = {ctx.spsel, ctx.npriv};

    pmc_sp_banks #(
        .SP_W       (SP_W),
        .ALIGN_BITS (ALIGN_BITS),
        .MSP_RST    (MSP_RST),
        .PSP_RST    (PSP_RST)
    ) u_banks (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (psp_active_o),
        .we_i    (sp_we_i),
        .wdata_i (sp_wdata_i),
        .rdata_o (sp_rdata_o)
    );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int SP_W       = 32,
    parameter int ALIGN_BITS = 2
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            exc_enter_i,
    input logic            exc_return_i,
    input logic [1:0]      exc_ret_code_i,
    input logic            ctrl_we_i,
    input logic [1:0]      ctrl_wdata_i,
    input logic [1:0]      ctrl_rdata_o,
    input logic            handler_mode_o,
    input logic            privileged_o,
    input logic            psp_active_o,
    input logic            sp_we_i,
    input logic [SP_W-1:0] sp_wdata_i,
    input logic [SP_W-1:0] sp_rdata_o
);

    localparam logic [SP_W-1:0] KEEP_MASK =
        {{(SP_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    // R2: entry lands in privileged handler mode on the main stack
    a_r2_entry_handler: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_enter_i |=> (handler_mode_o && privileged_o && !psp_active_o));

    // R3: privileged thread write takes both bits
    a_r3_priv_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_we_i && !handler_mode_o && privileged_o && !exc_enter_i)
        |=> (ctrl_rdata_o == $past(ctrl_wdata_i)));

    // R4: unprivileged thread writes change nothing
    a_r4_user_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_we_i && !handler_mode_o && !privileged_o)
        |=> ($stable(ctrl_rdata_o) && !privileged_o));

    // R5: return to thread restores privilege from stored bit 0
    a_r5_return_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_return_i && handler_mode_o && exc_ret_code_i[0] && !exc_enter_i && !ctrl_we_i)
        |=> (!handler_mode_o && (privileged_o == !$past(ctrl_rdata_o[0]))));

    // R7: exit strobe in thread mode is ignored
    a_r7_thread_return_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_return_i && !handler_mode_o && !exc_enter_i && !ctrl_we_i)
        |=> (!handler_mode_o && $stable(ctrl_rdata_o)));

    // R8: return code bit 1 picks the thread stack
    a_r8_return_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_return_i && handler_mode_o && exc_ret_code_i[0] && !exc_enter_i)
        |=> (psp_active_o == $past(exc_ret_code_i[1])));

    // R9: a write reads back aligned from the same bank
    a_r9_sp_aligned_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sp_we_i && !exc_enter_i && !exc_return_i && !ctrl_we_i)
        |=> (sp_rdata_o == ($past(sp_wdata_i) & KEEP_MASK)));

    // R10: coincident entry and exit end in handler mode
    a_r10_tail_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_enter_i && exc_return_i) |=> (handler_mode_o && privileged_o));

endmodule

bind priv_mode_ctrl pmc_checker #(
    .SP_W       (SP_W),
    .ALIGN_BITS (ALIGN_BITS)
) u_pmc_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .exc_enter_i    (exc_enter_i),
    .exc_return_i   (exc_return_i),
    .exc_ret_code_i (exc_ret_code_i),
    .ctrl_we_i      (ctrl_we_i),
    .ctrl_wdata_i   (ctrl_wdata_i),
    .ctrl_rdata_o   (ctrl_rdata_o),
    .handler_mode_o (handler_mode_o),
    .privileged_o   (privileged_o),
    .psp_active_o   (psp_active_o),
    .sp_we_i        (sp_we_i),
    .sp_wdata_i     (sp_wdata_i),
    .sp_rdata_o     (sp_rdata_o)
);

// File: tb/priv_mode_ctrl_tb_top.sv
module priv_mode_ctrl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          SP_W       = 32;
    localparam logic [31:0] MSP_RST    = 32'h2000_0000;
    localparam logic [31:0] PSP_RST    = 32'h1000_0000;
    localparam int          NVEC       = 17;

    // Fields: enter, ret, code[1:0], we, wdata[1:0] | exp handler, priv, psp, ctrl[1:0]
    localparam logic [11:0] VEC [NVEC] = '{
        12'b0_0_00_0_00_0_1_0_00, // 0  idle                      R1
        12'b0_0_00_1_01_0_0_0_01, // 1  drop privilege            R3
        12'b0_0_00_1_00_0_0_0_01, // 2  user tries to regain      R4
        12'b1_0_00_0_00_1_1_0_01, // 3  entry                     R2
        12'b0_1_01_0_00_0_0_0_01, // 4  return, user restored     R5
        12'b1_0_00_0_00_1_1_0_01, // 5  entry                     R2
        12'b0_0_00_1_00_1_1_0_00, // 6  handler clears bit 0      R6
        12'b0_1_11_0_00_0_1_1_10, // 7  return to process stack   R8
        12'b0_0_00_1_11_0_0_1_11, // 8  privileged write 11       R3
        12'b1_1_01_0_00_1_1_0_11, // 9  entry+exit from thread    R10
        12'b1_0_00_0_00_1_1_0_11, // 10 nested entry              R2
        12'b0_1_00_0_00_1_1_0_11, // 11 nested return             R7
        12'b0_1_11_0_00_0_0_1_11, // 12 return to thread          R5
        12'b0_1_01_0_00_0_0_1_11, // 13 exit in thread ignored    R7
        12'b1_0_00_0_00_1_1_0_11, // 14 entry                     R2
        12'b1_1_01_0_00_1_1_0_11, // 15 tail chain                R10
        12'b0_1_01_0_00_0_0_0_01  // 16 return to main stack      R8
    };

    function automatic string vec_req(int i);
        case (i)
            0:       return "R1";
            1, 8:    return "R3";
            2:       return "R4";
            4, 12:   return "R5";
            6:       return "R6";
            7, 16:   return "R8";
            11, 13:  return "R7";
            9, 15:   return "R10";
            default: return "R2";
        endcase
    endfunction

    logic            clk_i = 1'b0;
    logic            rst_ni;
    logic            exc_enter_i;
    logic            exc_return_i;
    logic [1:0]      exc_ret_code_i;
    logic            ctrl_we_i;
    logic [1:0]      ctrl_wdata_i;
    logic [1:0]      ctrl_rdata_o;
    logic            handler_mode_o;
    logic            privileged_o;
    logic            psp_active_o;
    logic            sp_we_i;
    logic [SP_W-1:0] sp_wdata_i;
    logic [SP_W-1:0] sp_rdata_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    priv_mode_ctrl #(
        .SP_W    (SP_W),
        .MSP_RST (MSP_RST),
        .PSP_RST (PSP_RST)
    ) dut_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .exc_enter_i    (exc_enter_i),
        .exc_return_i   (exc_return_i),
        .exc_ret_code_i (exc_ret_code_i),
        .ctrl_we_i      (ctrl_we_i),
        .ctrl_wdata_i   (ctrl_wdata_i),
        .ctrl_rdata_o   (ctrl_rdata_o),
        .handler_mode_o (handler_mode_o),
        .privileged_o   (privileged_o),
        .psp_active_o   (psp_active_o),
        .sp_we_i        (sp_we_i),
        .sp_wdata_i     (sp_wdata_i),
        .sp_rdata_o     (sp_rdata_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        exc_enter_i    = 1'b0;
        exc_return_i   = 1'b0;
        exc_ret_code_i = 2'b00;
        ctrl_we_i      = 1'b0;
        ctrl_wdata_i   = 2'b00;
        sp_we_i        = 1'b0;
        sp_wdata_i     = '0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    // Status word {handler, priv, psp, ctrl[1:0]}
    function automatic logic [4:0] status();
        return {handler_mode_o, privileged_o, psp_active_o, ctrl_rdata_o};
    endfunction

    task automatic sp_write(logic [31:0] val);
        sp_we_i    = 1'b1;
        sp_wdata_i = val;
        @(negedge clk_i);
        sp_we_i    = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 status", 32'(status()), 32'(5'b0_1_0_00));
        chk("R1 main sp", sp_rdata_o, MSP_RST);

        for (int i = 0; i < NVEC; i++) begin
            exc_enter_i    = VEC[i][11];
            exc_return_i   = VEC[i][10];
            exc_ret_code_i = VEC[i][9:8];
            ctrl_we_i      = VEC[i][7];
            ctrl_wdata_i   = VEC[i][6:5];
            @(negedge clk_i);
            idle_inputs();
            chk(vec_req(i), 32'(status()), 32'(VEC[i][4:0]));
        end

        // R9: stack bank directed sequence
        do_reset();
        sp_write(32'h0000_1003);
        chk("R9 main write aligned", sp_rdata_o, 32'h0000_1000);
        ctrl_we_i = 1'b1; ctrl_wdata_i = 2'b10;
        @(negedge clk_i);
        idle_inputs();
        chk("R1 process sp reset", sp_rdata_o, PSP_RST);
        chk("R3 process stack selected", 32'(psp_active_o), 32'd1);
        sp_write(32'h0000_2007);
        chk("R9 process write aligned", sp_rdata_o, 32'h0000_2004);
        exc_enter_i = 1'b1;
        @(negedge clk_i);
        idle_inputs();
        chk("R2 handler sees main sp", sp_rdata_o, 32'h0000_1000);
        sp_write(32'hFFFF_FFFF);
        chk("R9 handler write main", sp_rdata_o, 32'hFFFF_FFFC);
        exc_return_i = 1'b1; exc_ret_code_i = 2'b11;
        @(negedge clk_i);
        idle_inputs();
        chk("R9 process bank untouched", sp_rdata_o, 32'h0000_2004);
        ctrl_we_i = 1'b1; ctrl_wdata_i = 2'b00;
        @(negedge clk_i);
        idle_inputs();
        chk("R9 main bank kept handler write", sp_rdata_o, 32'hFFFF_FFFC);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule